// File: doc/BRIEF.md
# Single-Window Read Cache with Write Invalidation

This block sits between a requester and a slow memory port. It keeps a copy of one aligned window of a surface, 4096 bytes by default. It answers 1-, 2- and 4-byte reads from that copy. When a read falls outside the held window, the block first fetches the whole window from memory as a burst of 32-bit words. It then answers the read from the new copy.

Writes never update the copy. Each write goes straight to memory at its own address, with byte strobes, and the held window is dropped. A flush input drops the window without any memory traffic. An XRGB mode changes two things. A 4-byte read comes back with its top byte forced to all ones. A 4-byte write leaves byte 3 of the memory word untouched.

Requests are accepted one at a time. Each accepted request produces exactly one response pulse, either with data or with an error flag.

Top module: `line_read_cache`

## Requirements
- R1: The window is LINE_BYTES bytes, aligned on a LINE_BYTES boundary. A fill presents the request address with its low log2(LINE_BYTES) bits cleared on `mem_rd_addr`. The fill then takes LINE_BYTES/4 data beats, stored in order of increasing address.
- R2: After reset no window is held, so the first read always causes a fill.
- R3: A read inside the held window causes no memory traffic. Its response appears two cycles after the request is accepted.
- R4: `req_size` is encoded as 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes. Read data is little-endian. Byte k of a word sits at bits 8k+7:8k. 1- and 2-byte results are zero-extended.
- R5: On a miss, the response comes only after every beat of the window has arrived. `req_ready` stays low until that response.
- R6: Every write goes to memory as one beat:
  - `mem_wr_addr` is the request address with bits 1:0 cleared.
  - A 1-byte write strobes lane addr[1:0]. A 2-byte write strobes lanes addr[1]*2 and addr[1]*2+1. A 4-byte write strobes all lanes.
  - The data is placed on the strobed lanes.
  - The held window is dropped, so the next read of that window fetches it again.
- R7: With `xrgb_mode` set, a 4-byte read returns bits 31:24 as 0xFF. 1- and 2-byte reads are unaffected.
- R8: With `xrgb_mode` set, a 4-byte write strobes only lanes 0 to 2 (strobe 4'b0111), leaving byte 3 in memory unchanged.
- R9: A one-cycle `flush` drops the held window and causes no memory traffic. The next read of that window causes a fill.
- R10: A request with size 3, a 2-byte access at an odd address, or a 4-byte access with nonzero addr[1:0] gets a response with `rsp_err` set. It causes no memory traffic and does not drop the held window.
- R11: During and right after reset, `req_ready` is high and `rsp_valid`, `mem_rd_valid` and `mem_wr_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Drop the held window |
| xrgb_mode | input | 1 | Force alpha on 4-byte reads, skip byte 3 on 4-byte writes |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted when high with req_valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | 0 = byte, 1 = half-word, 2 = word |
| req_addr | input | AW | Byte address |
| req_wdata | input | 32 | Write data, right-aligned |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_data | output | 32 | Read result |
| rsp_err | output | 1 | Request rejected as misaligned or bad size |
| mem_rd_valid | output | 1 | Fill burst request |
| mem_rd_ready | input | 1 | Fill burst request taken |
| mem_rd_addr | output | AW | Window base address of the fill |
| mem_rd_beat_valid | input | 1 | Fill data beat present |
| mem_rd_beat_data | input | 32 | Fill data beat |
| mem_wr_valid | output | 1 | Write beat present |
| mem_wr_ready | input | 1 | Write beat taken |
| mem_wr_addr | output | AW | Word-aligned write address |
| mem_wr_data | output | 32 | Write data on byte lanes |
| mem_wr_strb | output | 4 | Byte lane enables |

## Verification
A stale window tag shows up at the ports in two ways. If it claims a hit after a write or a flush, the next read returns old bytes with no fill and a two-cycle latency. If it claims a miss on a held window, an unexpected fill burst appears on `mem_rd_valid`. Either way the effect is visible on the very next read. A wrong fill count or beat order shows as wrong data somewhere in the window. A sweep over every aligned offset at every size therefore exposes it within one window's worth of reads. A wrong strobe or lane shows as a corrupted neighbour byte when that word is read back after the write.

// File: rtl/line_read_cache.sv
module line_read_cache #(
  parameter int AW = 32,
  parameter int LINE_BYTES = 4096
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          xrgb_mode,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [1:0]    req_size,
  input  logic [AW-1:0] req_addr,
  input  logic [31:0]   req_wdata,
  output logic          rsp_valid,
  output logic [31:0]   rsp_data,
  output logic          rsp_err,
  output logic          mem_rd_valid,
  input  logic          mem_rd_ready,
  output logic [AW-1:0] mem_rd_addr,
  input  logic          mem_rd_beat_valid,
  input  logic [31:0]   mem_rd_beat_data,
  output logic          mem_wr_valid,
  input  logic          mem_wr_ready,
  output logic [AW-1:0] mem_wr_addr,
  output logic [31:0]   mem_wr_data,
  output logic [3:0]    mem_wr_strb
);
  localparam int OFF_W = $clog2(LINE_BYTES);
  localparam int WORDS = LINE_BYTES / 4;
  localparam int WIDX_W = OFF_W - 2;
  localparam int CNT_W = WIDX_W + 1;
  localparam logic [AW-1:0] NO_LINE = '1;

  typedef enum logic [2:0] {S_IDLE, S_CHECK, S_FILL_REQ, S_FILL, S_WRITE} state_t;
  state_t state;

  logic [31:0]    line_mem [WORDS];
  logic [AW-1:0]  line_base;
  logic [CNT_W-1:0] fill_cnt;
  logic           q_write, q_xrgb;
  logic [1:0]     q_size;
  logic [AW-1:0]  q_addr;
  logic [31:0]    q_wdata;

  logic [AW-1:0]  q_base;
  logic           hit, misalign;
  logic [31:0]    word, rd_val;

  assign q_base   = {q_addr[AW-1:OFF_W], {OFF_W{1'b0}}};
  assign hit      = (q_base == line_base);
  assign misalign = (q_size == 2'd3) || (q_size == 2'd1 && q_addr[0]) ||
                    (q_size == 2'd2 && q_addr[1:0] != 2'b00);
  assign word     = line_mem[q_addr[OFF_W-1:2]];

  always_comb begin
    case (q_size)
      2'd0:    rd_val = {24'h0, word[{q_addr[1:0], 3'b000} +: 8]};
      2'd1:    rd_val = {16'h0, word[{q_addr[1], 4'b0000} +: 16]};
      default: rd_val = q_xrgb ? {8'hFF, word[23:0]} : word;
    endcase
  end

  always_comb begin
    case (q_size)
      2'd0: begin
        mem_wr_data = {4{q_wdata[7:0]}};
        mem_wr_strb = 4'b0001 << q_addr[1:0];
      end
      2'd1: begin
        mem_wr_data = {2{q_wdata[15:0]}};
        mem_wr_strb = q_addr[1] ? 4'b1100 : 4'b0011;
      end
      default: begin
        mem_wr_data = q_wdata;
        mem_wr_strb = q_xrgb ? 4'b0111 : 4'b1111;
      end
    endcase
  end

  assign req_ready    = (state == S_IDLE);
  assign mem_rd_valid = (state == S_FILL_REQ);
  assign mem_rd_addr  = q_base;
  assign mem_wr_valid = (state == S_WRITE);
  assign mem_wr_addr  = {q_addr[AW-1:2], 2'b00};

  always_ff @(posedge clk) begin
    if (state == S_FILL && mem_rd_beat_valid)
      line_mem[fill_cnt[WIDX_W-1:0]] <= mem_rd_beat_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      line_base <= NO_LINE;
      fill_cnt  <= '0;
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
      rsp_err   <= 1'b0;
      q_write   <= 1'b0;
      q_xrgb    <= 1'b0;
      q_size    <= '0;
      q_addr    <= '0;
      q_wdata   <= '0;
    end else begin
      rsp_valid <= 1'b0;
      case (state)
        S_IDLE: if (req_valid) begin
          q_write <= req_write;
          q_xrgb  <= xrgb_mode;
          q_size  <= req_size;
          q_addr  <= req_addr;
          q_wdata <= req_wdata;
          state   <= S_CHECK;
        end
        S_CHECK: begin
          if (misalign) begin
            rsp_valid <= 1'b1;
            rsp_err   <= 1'b1;
            rsp_data  <= '0;
            state     <= S_IDLE;
          end else if (q_write) begin
            line_base <= NO_LINE;
            state     <= S_WRITE;
          end else if (hit) begin
            rsp_valid <= 1'b1;
            rsp_err   <= 1'b0;
            rsp_data  <= rd_val;
            state     <= S_IDLE;
          end else begin
            fill_cnt <= '0;
            state    <= S_FILL_REQ;
          end
        end
        S_FILL_REQ: if (mem_rd_ready) state <= S_FILL;
        S_FILL: if (mem_rd_beat_valid) begin
          fill_cnt <= fill_cnt + 1'b1;
          if (fill_cnt == CNT_W'(WORDS - 1)) begin
            line_base <= q_base;
            state     <= S_CHECK;
          end
        end
        S_WRITE: if (mem_wr_ready) begin
          rsp_valid <= 1'b1;
          rsp_err   <= 1'b0;
          rsp_data  <= '0;
          state     <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
      if (flush) line_base <= NO_LINE;
    end
  end

  assert_hit_no_fill_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_CHECK && !q_write && !misalign && hit) |=> (rsp_valid && !mem_rd_valid));

  assert_fill_stalls_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_valid && mem_rd_ready) |=> (!req_ready && !rsp_valid));

  assert_write_drops_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_valid |-> (line_base == NO_LINE));

  assert_flush_drops_R9: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (line_base == NO_LINE));

  assert_err_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_err) |-> (!mem_rd_valid && !mem_wr_valid && ($stable(line_base) || $past(flush))));

  assert_single_rsp_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
endmodule

// File: tb/line_read_cache_test.sv
module line_read_cache_test;
  localparam int AW = 12;
  localparam int LB = 64;
  localparam int NW = (1 << AW) / 4;

  logic clk = 0, rst_n = 0, flush = 0, xrgb_mode = 0;
  logic req_valid = 0, req_write = 0;
  logic [1:0] req_size = 0;
  logic [AW-1:0] req_addr = 0;
  logic [31:0] req_wdata = 0;
  logic req_ready, rsp_valid, rsp_err;
  logic [31:0] rsp_data;
  logic mem_rd_valid, mem_wr_valid;
  logic [AW-1:0] mem_rd_addr, mem_wr_addr;
  logic mem_rd_beat_valid = 0;
  logic [31:0] mem_rd_beat_data = 0;
  logic [31:0] mem_wr_data;
  logic [3:0] mem_wr_strb;

  always #10 clk = ~clk;

  line_read_cache #(.AW(AW), .LINE_BYTES(LB)) uut (
    .clk(clk), .rst_n(rst_n), .flush(flush), .xrgb_mode(xrgb_mode),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_size(req_size), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_err(rsp_err),
    .mem_rd_valid(mem_rd_valid), .mem_rd_ready(1'b1), .mem_rd_addr(mem_rd_addr),
    .mem_rd_beat_valid(mem_rd_beat_valid), .mem_rd_beat_data(mem_rd_beat_data),
    .mem_wr_valid(mem_wr_valid), .mem_wr_ready(1'b1), .mem_wr_addr(mem_wr_addr),
    .mem_wr_data(mem_wr_data), .mem_wr_strb(mem_wr_strb));

  logic [31:0] bmem [NW];
  int rd_bursts = 0, wr_count = 0, beats_left = 0, beat_idx = 0;
  logic [AW-1:0] last_rd_addr = 0, last_wr_addr = 0;
  logic [3:0] last_wr_strb = 0;
  logic [31:0] last_wr_data = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NW; i++) bmem[i] <= (i * 32'h9E3779B1) ^ 32'h5A5A0F0F;
      mem_rd_beat_valid <= 0;
      beats_left <= 0;
    end else begin
      if (beats_left > 0) begin
        mem_rd_beat_valid <= 1;
        mem_rd_beat_data <= bmem[beat_idx];
        beat_idx <= beat_idx + 1;
        beats_left <= beats_left - 1;
      end else mem_rd_beat_valid <= 0;
      if (mem_rd_valid) begin
        rd_bursts <= rd_bursts + 1;
        last_rd_addr <= mem_rd_addr;
        beat_idx <= int'(mem_rd_addr) / 4;
        beats_left <= LB / 4;
      end
      if (mem_wr_valid) begin
        wr_count <= wr_count + 1;
        last_wr_addr <= mem_wr_addr;
        last_wr_strb <= mem_wr_strb;
        last_wr_data <= mem_wr_data;
        for (int b = 0; b < 4; b++)
          if (mem_wr_strb[b]) bmem[mem_wr_addr[AW-1:2]][8*b +: 8] <= mem_wr_data[8*b +: 8];
      end
    end
  end

  int total = 0, fails = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_read(input logic [AW-1:0] a, input logic [1:0] sz, input bit x);
    logic [31:0] w = bmem[a[AW-1:2]];
    case (sz)
      2'd0: return {24'h0, w[8*a[1:0] +: 8]};
      2'd1: return {16'h0, w[16*a[1] +: 16]};
      default: return x ? {8'hFF, w[23:0]} : w;
    endcase
  endfunction

  logic [31:0] r_data;
  logic r_err;
  int r_lat;

  task automatic do_req(input bit w, input logic [1:0] sz, input logic [AW-1:0] a, input logic [31:0] d, input bit x);
    @(negedge clk);
    req_valid = 1; req_write = w; req_size = sz; req_addr = a; req_wdata = d; xrgb_mode = x;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 0;
    r_lat = 1;
    while (!rsp_valid && r_lat < 500) begin
      @(negedge clk);
      r_lat++;
    end
    r_data = rsp_data;
    r_err = rsp_err;
    xrgb_mode = 0;
  endtask

  task automatic rd_check(input logic [1:0] sz, input logic [AW-1:0] a, input bit x, input bit expect_fill, input string tag);
    int b0 = rd_bursts;
    logic [31:0] e;
    do_req(0, sz, a, 0, x);
    e = exp_read(a, sz, x);
    chk(r_data == e && !r_err, tag, r_data, e);
    chk((rd_bursts - b0) == (expect_fill ? 1 : 0), {tag, " fill count"}, rd_bursts - b0, expect_fill ? 1 : 0);
    if (!expect_fill) chk(r_lat == 2, {tag, " hit latency"}, r_lat, 2);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++; total++;
    $display("FAIL watchdog actual=%0d expected=done", total);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    logic [7:0] old_b3;
    int b0, w0;
    repeat (3) @(negedge clk);
    chk(req_ready && !rsp_valid && !mem_rd_valid && !mem_wr_valid, "R11 reset outputs",
        {req_ready, rsp_valid, mem_rd_valid, mem_wr_valid}, 4'b1000);
    rst_n = 1;
    @(negedge clk);
    chk(req_ready && !rsp_valid && !mem_rd_valid && !mem_wr_valid, "R11 after reset",
        {req_ready, rsp_valid, mem_rd_valid, mem_wr_valid}, 4'b1000);

    rd_check(2, 12'h108, 0, 1, "R2 first read fills");
    chk(last_rd_addr == 12'h100, "R1 fill base", last_rd_addr, 12'h100);
    chk(r_lat > LB / 4, "R5 response after all beats", r_lat, LB / 4);

    for (int a = 12'h100; a < 12'h140; a++) rd_check(0, a[AW-1:0], 0, 0, "R4 byte sweep R3");
    for (int a = 12'h100; a < 12'h140; a += 2) rd_check(1, a[AW-1:0], 0, 0, "R4 half sweep R3");
    for (int a = 12'h100; a < 12'h140; a += 4) rd_check(2, a[AW-1:0], 0, 0, "R4 word sweep R3");

    for (int k = 0; k < 8; k++) begin
      rd_check(2, AW'(k * LB + 12'h400 + 4 * k), 0, 1, "R1 window walk");
      chk(last_rd_addr == AW'(k * LB + 12'h400), "R1 walk base", last_rd_addr, AW'(k * LB + 12'h400));
    end

    rd_check(0, 12'h345, 0, 1, "R1 new window");
    chk(last_rd_addr == 12'h340, "R1 base clears low bits", last_rd_addr, 12'h340);

    b0 = rd_bursts; w0 = wr_count;
    do_req(0, 1, 12'h341, 0, 0);
    chk(r_err, "R10 odd half", r_err, 1);
    do_req(0, 2, 12'h342, 0, 0);
    chk(r_err, "R10 unaligned word", r_err, 1);
    do_req(1, 3, 12'h344, 32'hDEAD, 0);
    chk(r_err, "R10 size 3", r_err, 1);
    chk(rd_bursts == b0 && wr_count == w0, "R10 no traffic", rd_bursts - b0 + wr_count - w0, 0);
    rd_check(2, 12'h348, 0, 0, "R10 window kept");

    w0 = wr_count;
    do_req(1, 0, 12'h346, 32'h000000AB, 0);
    chk(wr_count == w0 + 1 && !r_err, "R6 write forwarded", wr_count - w0, 1);
    chk(last_wr_addr == 12'h344 && last_wr_strb == 4'b0100, "R6 byte strobe", {last_wr_addr, last_wr_strb}, {12'h344, 4'b0100});
    chk(last_wr_data[23:16] == 8'hAB, "R6 byte lane", last_wr_data[23:16], 8'hAB);
    rd_check(0, 12'h346, 0, 1, "R6 write drops window");
    chk(r_data == 32'hAB, "R6 byte reaches memory", r_data, 32'hAB);

    do_req(1, 1, 12'h342, 32'h0000BEEF, 0);
    chk(last_wr_strb == 4'b1100 && last_wr_data[31:16] == 16'hBEEF, "R6 half strobe", {last_wr_strb, last_wr_data[31:16]}, {4'b1100, 16'hBEEF});
    rd_check(1, 12'h342, 0, 1, "R6 half readback");
    do_req(1, 2, 12'h348, 32'hCAFEF00D, 0);
    chk(last_wr_strb == 4'b1111 && last_wr_data == 32'hCAFEF00D, "R6 word strobe", last_wr_data, 32'hCAFEF00D);
    rd_check(2, 12'h348, 0, 1, "R6 word readback");

    rd_check(2, 12'h34C, 1, 0, "R7 alpha forced");
    rd_check(0, 12'h34F, 1, 0, "R7 byte unaffected");
    rd_check(1, 12'h34E, 1, 0, "R7 half unaffected");

    old_b3 = bmem[12'h350 >> 2][31:24];
    do_req(1, 2, 12'h350, 32'h11223344, 1);
    chk(last_wr_strb == 4'b0111, "R8 three-byte strobe", last_wr_strb, 4'b0111);
    rd_check(2, 12'h350, 0, 1, "R8 readback");
    chk(r_data == {old_b3, 24'h223344}, "R8 byte 3 kept", r_data, {old_b3, 24'h223344});

    rd_check(2, 12'h354, 0, 0, "R9 held before flush");
    b0 = rd_bursts; w0 = wr_count;
    @(negedge clk); flush = 1;
    @(negedge clk); flush = 0;
    repeat (3) @(negedge clk);
    chk(rd_bursts == b0 && wr_count == w0, "R9 flush no traffic", rd_bursts - b0 + wr_count - w0, 0);
    rd_check(2, 12'h354, 0, 1, "R9 refetch after flush");

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule